// File: doc/BRIEF.md
# Systolic Square-Matrix Multiplier

This block computes the product C = A·B of two N×N unsigned matrices on a grid of N×N identical multiply-accumulate cells. Each cell owns exactly one result element and keeps it in place. A operands travel to the right along the grid rows. B operands travel downward along the grid columns. A pulse on `start` latches both matrices from the parallel input buses and clears every accumulator. The block then streams the operands into the grid edges with a diagonal skew, so each element enters the grid once.

Row i of A enters i ticks after row 0, with its elements in index order. Column j of B enters j ticks after column 0, also in index order. A lane with no element to deliver on a given tick feeds zero. After 3N−2 ticks every cell has seen all N of its operand pairs. `done` then pulses for one cycle, and the result bus holds C until the next `start`.

Top module: `sys_matmul`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `done` low and every result element zero.
- R2: In the cycle after a clock edge that samples `start` high, every element of `c_mat` is zero.
- R3: Once computation completes, element (i,j) of `c_mat` equals the unsigned sum over k of A(i,k)·B(k,j). Rows and columns count from 0. Element (i,j) of A sits at bit offset (i·N+j)·W of `a_mat`, and B uses the same packing in `b_mat`. Element (i,j) of C sits at bit offset (i·N+j)·AW of `c_mat`, where AW = 2W + ceil(log2 N).
- R4: `done` is high for exactly one cycle. That cycle comes after the 3N−2-th clock edge that follows the edge sampling `start`. `done` is never high at any other time.
- R5: After `done`, the result elements stay unchanged until the next `start`.
- R6: The accumulators never wrap. With every operand at 2^W−1, each result equals N·(2^W−1)², and no result element ever decreases except through `start` or reset.
- R7: A `start` that arrives during a computation abandons it and begins a new one with the matrices present at that edge. `done` then follows only that last `start`, 3N−2 edges after it.
- R8: The matrices are captured at the `start` edge. Changes on `a_mat` or `b_mat` after that edge have no effect on the result.
- R9: After t ticks (the clock edges after the start edge), result (i,j) equals the sum of A(i,k)·B(k,j) over those k with i+j+k < t. This is the diagonal wavefront produced by the injection skew.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Latch both matrices, clear accumulators, begin a multiplication |
| a_mat | input | N·N·W | Left operand matrix, row-major |
| b_mat | input | N·N·W | Right operand matrix, row-major |
| done | output | 1 | One-cycle pulse when the product is complete |
| c_mat | output | N·N·AW | Product matrix, row-major, one accumulator per element |

## Verification
The bench builds the block with N=3 and 4-bit operands, which gives 10-bit accumulators and a 7-tick computation. Operands this narrow let the all-ones case reach the true accumulator ceiling (675 of 1023). The bench also sweeps a single nonzero A element through all nine positions, which isolates each k-lane path through the grid. The sweep is followed by seeded pseudo-random matrices. The partial products are compared after every tick, so skew errors in any lane or forwarding stage show up as a wrong wavefront before they corrupt the final result.

// File: rtl/mm_pkg.sv
// Package: shared types and width helpers for the systolic multiplier.
// Assumes unsigned operands; accumulator width grows with log2 of the depth.
package mm_pkg;

    // Sequencer state: idle between products, run while ticks are issued
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    // Bits needed to sum n products of two w-bit unsigned values
    function automatic int acc_bits(input int w, input int n);
        return 2 * w + $clog2(n);
    endfunction

endpackage

// File: rtl/sa_cell.sv
// Module: sa_cell
// One multiply-accumulate cell of the grid. It holds one result element and
// adds the product of the operand pair it sees on each enabled tick.
// Assumes AW >= 2*W and that clr takes priority over en.
module sa_cell #(
    parameter int W  = 8,
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [AW-1:0] acc
);

    logic [2*W-1:0] prod;

    // Full-width unsigned product of the pair presented this tick
    assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

    // Accumulate the product; cleared by reset or a new start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + AW'(prod);
        end
    end

endmodule

// File: rtl/sa_fwd.sv
// Module: sa_fwd
// Operand forwarding stage between two neighbouring cells. It delays an
// operand by one tick so it reaches the next cell on the following tick.
// Assumes en is the run strobe and clr the start strobe.
module sa_fwd #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Hold the operand for one tick; flushed to zero on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sa_feed.sv
// Module: sa_feed
// Captures one operand matrix at start and presents one skewed edge lane per
// grid row (COLS=0, matrix A) or grid column (COLS=1, matrix B). On tick t,
// lane l carries element index k = t - l when 0 <= k < N, and zero otherwise.
// Assumes the tick counter starts at 0 on the first tick after start.
module sa_feed #(
    parameter int N    = 3,
    parameter int W    = 8,
    parameter int TW   = 4,
    parameter bit COLS = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [N*N*W-1:0] mat,
    input  logic [TW-1:0]    tick,
    output logic [N*W-1:0]   lanes
);

    logic [N*N*W-1:0] mat_q;

    // Latch the whole matrix once per multiplication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mat_q <= '0;
        end else if (load) begin
            mat_q <= mat;
        end
    end

    for (genvar l = 0; l < N; l++) begin : g_lane
        logic [W-1:0] pick;

        if (COLS) begin : g_col
            // Column lane l: walk down column l of the matrix, skewed by l
            always_comb begin
                pick = '0;
                for (int k = 0; k < N; k++) begin
                    if (int'(tick) == l + k) begin
                        pick = mat_q[(k*N + l)*W +: W];
                    end
                end
            end
        end else begin : g_row
            // Row lane l: walk along row l of the matrix, skewed by l
            always_comb begin
                pick = '0;
                for (int k = 0; k < N; k++) begin
                    if (int'(tick) == l + k) begin
                        pick = mat_q[(l*N + k)*W +: W];
                    end
                end
            end
        end

        assign lanes[l*W +: W] = pick;
    end

endmodule

// File: rtl/sa_ctrl.sv
// Module: sa_ctrl
// Sequencer for one multiplication. A start restarts the tick counter and
// enters the run state. After 3N-2 ticks it returns to idle and pulses done.
// Assumes start may arrive at any time, including mid-run.
module sa_ctrl
    import mm_pkg::*;
#(
    parameter int N  = 3,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          run,
    output logic [TW-1:0] tick,
    output logic          done
);

    localparam logic [TW-1:0] LAST_TICK = TW'(3*N - 3);

    seq_state_t st;

    // Advance the tick counter and flag completion on the final tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SEQ_IDLE;
            tick <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                st   <= SEQ_RUN;
                tick <= '0;
            end else if (st == SEQ_RUN) begin
                tick <= tick + TW'(1);
                if (tick == LAST_TICK) begin
                    st   <= SEQ_IDLE;
                    done <= 1'b1;
                end
            end
        end
    end

    // Cells and forwarding stages advance only while running
    assign run = (st == SEQ_RUN);

endmodule

// File: rtl/sys_matmul.sv
// Module: sys_matmul (top)
// Output-stationary N x N systolic multiplier. Two feeders inject skewed
// lanes of A (left edge) and B (top edge). Forwarding stages pass A right and
// B down one cell per tick. Each cell accumulates its own element of C.
// Assumes N >= 2 and unsigned operands.
module sys_matmul
    import mm_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 8,
    localparam int AW = acc_bits(W, N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*N*W-1:0]  a_mat,
    input  logic [N*N*W-1:0]  b_mat,
    output logic              done,
    output logic [N*N*AW-1:0] c_mat
);

    localparam int TW = $clog2(3*N);

    logic          run;
    logic [TW-1:0] tick;
    logic [N*W-1:0] a_lane;
    logic [N*W-1:0] b_lane;

    wire [W-1:0] a_op [N][N];
    wire [W-1:0] b_op [N][N];

    sa_ctrl #(.N(N), .TW(TW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .run   (run),
        .tick  (tick),
        .done  (done)
    );

    sa_feed #(.N(N), .W(W), .TW(TW), .COLS(1'b0)) u_feed_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .mat   (a_mat),
        .tick  (tick),
        .lanes (a_lane)
    );

    sa_feed #(.N(N), .W(W), .TW(TW), .COLS(1'b1)) u_feed_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .mat   (b_mat),
        .tick  (tick),
        .lanes (b_lane)
    );

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col

            if (c == 0) begin : g_a_edge
                assign a_op[r][c] = a_lane[r*W +: W];
            end else begin : g_a_fwd
                sa_fwd #(.W(W)) u_fa (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr   (start),
                    .en    (run),
                    .d     (a_op[r][c-1]),
                    .q     (a_op[r][c])
                );
            end

            if (r == 0) begin : g_b_edge
                assign b_op[r][c] = b_lane[c*W +: W];
            end else begin : g_b_fwd
                sa_fwd #(.W(W)) u_fb (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr   (start),
                    .en    (run),
                    .d     (b_op[r-1][c]),
                    .q     (b_op[r][c])
                );
            end

            sa_cell #(.W(W), .AW(AW)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .en    (run),
                .a     (a_op[r][c]),
                .b     (b_op[r][c]),
                .acc   (c_mat[(r*N + c)*AW +: AW])
            );
        end
    end

endmodule

// File: rtl/sa_matmul_chk.sv
// Module: sa_matmul_chk
// Protocol checker for sys_matmul, attached by bind. It tracks the cycles
// since the last start to check the completion timing without deep $past.
module sa_matmul_chk
    import mm_pkg::*;
#(
    parameter int N = 3,
    parameter int W = 8,
    localparam int AW = acc_bits(W, N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [N*N*AW-1:0] c_mat
);

    localparam int CW  = $clog2(3*N + 1) + 1;
    localparam logic [CW-1:0] TOT = CW'(3*N - 2);
    localparam logic [CW-1:0] SAT = CW'(3*N);

    logic [CW-1:0] cnt;
    logic          busy;

    // Count edges since the last start; busy until the done pulse is seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else begin
            if (cnt != SAT) cnt <= cnt + CW'(1);
            if (done) busy <= 1'b0;
        end
    end

    // R4: done only at the expected distance from the last start
    assert_done_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && cnt == TOT));

    // R4: the expected distance always produces done
    assert_done_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == TOT) |-> done);

    // R4: single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: start clears every result element
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (c_mat == '0));

    // R5: results hold while idle
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(c_mat));

    // R6: accumulators never wrap downward
    for (genvar e = 0; e < N*N; e++) begin : g_mono
        assert_acc_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !start |=> (c_mat[e*AW +: AW] >= $past(c_mat[e*AW +: AW])));
    end

endmodule

bind sys_matmul sa_matmul_chk #(.N(N), .W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .c_mat (c_mat)
);

// File: tb/sim_sys_matmul.sv
module sim_sys_matmul;

    localparam int N       = 3;
    localparam int W       = 4;
    localparam int AW      = 2*W + $clog2(N);
    localparam int TOT     = 3*N - 2;
    localparam int CLK_PER = 10;
    localparam int MAXV    = (1 << W) - 1;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*N*W-1:0]  a_bus = '0;
    logic [N*N*W-1:0]  b_bus = '0;
    logic              done;
    logic [N*N*AW-1:0] c_bus;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h2f6b_91c3;
    int ea [N][N];
    int eb [N][N];

    always #(CLK_PER/2) clk = ~clk;

    sys_matmul #(.N(N), .W(W)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a_mat (a_bus),
        .b_mat (b_bus),
        .done  (done),
        .c_mat (c_bus)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int unsigned nxt();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    // Partial product after m ticks: only k with r+c+k < m has arrived
    function automatic int expect_el(input int r, input int c, input int m);
        int s = 0;
        for (int k = 0; k < N; k++)
            if (r + c + k <= m - 1) s += ea[r][k] * eb[k][c];
        return s;
    endfunction

    task automatic cmp_mat(input int m, input string req);
        bit ok = 1'b1;
        int fa = 0;
        int fe = 0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                int act = int'(c_bus[(r*N + c)*AW +: AW]);
                int e   = expect_el(r, c, m);
                if (act != e && ok) begin
                    ok = 1'b0; fa = act; fe = e;
                end
            end
        chk(ok, req, fa, fe);
    endtask

    task automatic pack();
        for (int r = 0; r < N; r++)
            for (int k = 0; k < N; k++) begin
                a_bus[(r*N + k)*W +: W] = W'(ea[r][k]);
                b_bus[(r*N + k)*W +: W] = W'(eb[r][k]);
            end
    endtask

    // One multiplication: checks clear, wavefront, done timing, result, hold
    task automatic run_mul(input bit scramble, input string tag);
        @(negedge clk);
        pack();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin
            a_bus = ~a_bus;
            b_bus = b_bus ^ {(N*N*W/2){2'b10}};
        end
        chk(c_bus == '0, "R2", int'(|c_bus), 0);
        chk(done == 1'b0, "R4", int'(done), 0);
        for (int m = 1; m <= TOT + 1; m++) begin
            @(negedge clk);
            chk(done == (m == TOT), "R4", int'(done), int'(m == TOT));
            if (m < TOT)       cmp_mat(m, "R9");
            else if (m == TOT) cmp_mat(TOT, tag);
            else               cmp_mat(TOT, "R5");
        end
        repeat (3) @(negedge clk);
        cmp_mat(TOT, "R5");
        chk(done == 1'b0, "R4", int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 1'b0, "R1", int'(done), 0);
        chk(c_bus == '0, "R1", int'(|c_bus), 0);
        rst_n = 1'b1;

        // R3: identity times random
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ea[r][c] = (r == c) ? 1 : 0;
                eb[r][c] = int'(nxt() % (MAXV + 1));
            end
        run_mul(1'b0, "R3");

        // R3: zero matrices
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ea[r][c] = 0; eb[r][c] = 0;
            end
        run_mul(1'b0, "R3");

        // R6: every operand at its maximum
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ea[r][c] = MAXV; eb[r][c] = MAXV;
            end
        run_mul(1'b0, "R6");

        // R3: single nonzero A element swept through every position
        for (int p = 0; p < N*N; p++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    ea[r][c] = (r*N + c == p) ? MAXV : 0;
                    eb[r][c] = int'(nxt() % (MAXV + 1));
                end
            run_mul(1'b0, "R3");
        end

        // R3: pseudo-random matrices
        for (int t = 0; t < 12; t++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    ea[r][c] = int'(nxt() % (MAXV + 1));
                    eb[r][c] = int'(nxt() % (MAXV + 1));
                end
            run_mul(1'b0, "R3");
        end

        // R8: inputs disturbed after the start edge
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ea[r][c] = int'(nxt() % (MAXV + 1));
                eb[r][c] = int'(nxt() % (MAXV + 1));
            end
        run_mul(1'b1, "R8");

        // R7: restart two ticks into a run
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ea[r][c] = MAXV; eb[r][c] = 1 + r;
            end
        @(negedge clk);
        pack();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            chk(done == 1'b0, "R7", int'(done), 0);
        end
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ea[r][c] = int'(nxt() % (MAXV + 1));
                eb[r][c] = int'(nxt() % (MAXV + 1));
            end
        run_mul(1'b0, "R7");

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule